// File: doc/BRIEF.md
# Serial ADC Lane Deserializer With Word Alignment

This block receives one serial lane from a 12-bit converter and turns it back into parallel signed samples. The lane carries one bit per bit-clock cycle, least significant bit first. A frame marker input, sampled on the same clock, flags the bit cycle that the block treats as the first bit of a word. Each completed word leaves as a two's-complement sample with a one-cycle valid strobe. The converter's offset-binary code is turned into two's complement by inverting the top bit.

The frame marker may not line up with the real word edge. For that case the block keeps a two-word history of the lane and takes each word from a window that can move to older bits, one bit position at a time. After reset it starts a training search. Each captured word is checked against a known test signal. That signal is either a fixed programmed pattern, which is bit-reversed before the compare because of the transmit order, or an incrementing ramp. On a mismatch the window moves one bit, the block waits a few frames, and then checks again. After a run of matching words it reports lock. If no window position matches, it reports failure. A training-enable input chooses whether locked traffic is still checked (pattern data) or passed through unchecked (live data).

Top module: `adc_lane_deser`

## Requirements
- R1: With the frame marker on the first transmitted bit of each word and no slip, the first bit after a marker ends up in bit 0 of the captured word, and the next eleven bits fill bits 1 to 11 in order.
- R2: The output sample equals the captured 12-bit code with bit 11 inverted (code XOR 0x800), read as signed. Code 0x000 gives -2048, 0xFFF gives 2047, and 0x800 gives 0.
- R3: On every clock cycle where the frame marker is high, valid is high for exactly the following cycle. Valid is low at all other times, and the sample holds its value between strobes.
- R4: A slip moves the capture window one bit toward older bits. It takes effect only in a frame-marker cycle, never goes past position 11, and lets the block align to a marker that lands on any bit 0 to 11 of the real word.
- R5: After reset and after each slip, the block ignores the next 4 captured words before it compares again. A perfectly aligned pattern after reset raises lock at the 20th frame marker.
- R6: In fixed-pattern training, a captured word matches when it equals the programmed pattern with its 12 bits reversed (pattern bit i compared with word bit 11-i).
- R7: In ramp training, a captured word matches when it equals the previous captured word plus one, modulo 4096, so 0xFFF followed by 0x000 matches.
- R8: Lock rises only after 16 consecutive matching words in training. A mismatch during the search resets the run and slips the window.
- R9: While locked and with training enabled, a mismatching word drops lock and sets an error flag. The error flag stays set until reset, even after lock is regained through 16 further matches.
- R10: While locked with training disabled, captured words are not compared. Lock and the error flag keep their values whatever data arrives.
- R11: A mismatch at slip position 11 raises a failure flag. The failure flag stays set until reset, and lock is never high at the same time.
- R12: A synchronous reset clears the history, the slip position, lock, the error and failure flags and valid, and restarts the training search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdata | input | 1 | Serial lane data, least significant bit first |
| frame | input | 1 | Frame marker; high in the cycle treated as the first bit of a word |
| train | input | 1 | 1: locked traffic is checked against the test signal; 0: live data |
| use_ramp | input | 1 | Test signal select: 1 ramp, 0 fixed pattern |
| cust_pat | input | 12 | Programmed fixed pattern, before bit reversal |
| sample | output | 12 | Signed two's-complement sample |
| valid | output | 1 | One-cycle strobe for a new sample |
| lock | output | 1 | Lane aligned and verified |
| err | output | 1 | Sticky: mismatch seen while locked in training |
| fail | output | 1 | Sticky: no slip position produced a match |

## Verification
The bound checker watches several rules on every cycle. Valid must follow the frame marker and the sample must hold between strobes. The slip position may change only one step at a time, only right after a marker, and never past 11. The error and failure flags must stay set once raised, lock and failure must never be high together, lock may rise only after a matching capture, and lock must stay up in live mode. Some results only the bench scenarios can show, because they depend on real lane streams: which slip position the search settles on for each marker offset, that the bit-reversed pattern and the ramp across the 4095-to-0 wrap are accepted, the exact frame on which lock first rises, and the signed value that comes out for each code.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;

    typedef enum logic [1:0] {
        AL_SETTLE = 2'd0,
        AL_CHECK  = 2'd1,
        AL_LOCKED = 2'd2,
        AL_FAILED = 2'd3
    } align_state_e;

endpackage

// File: rtl/adc_bit_window.sv
// Two-word serial history with a slip-selected capture window.
module adc_bit_window #(
    parameter int W      = 12,
    parameter int SLIP_W = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdata,
    input  logic [SLIP_W-1:0] slip,
    output logic [W-1:0]      word_o
);
    localparam int HIST_W = 2 * W;
    localparam logic [SLIP_W:0] W_L = (SLIP_W + 1)'(W);

    logic [HIST_W-1:0] hist_d, hist_q;
    logic [SLIP_W:0]   shamt;
    logic [HIST_W-1:0] shifted;

    always_comb begin
        // newest bit enters at the top, older bits move toward bit 0
        hist_d  = {sdata, hist_q[HIST_W-1:1]};
        // slip 0 takes the newest W bits; each slip step moves one bit older
        shamt   = W_L - {1'b0, slip};
        shifted = hist_q >> shamt;
        word_o  = shifted[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_d;
    end
endmodule

// File: rtl/adc_pattern_check.sv
// Compares captured words with the reversed fixed pattern or a ramp.
module adc_pattern_check #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] word,
    input  logic         use_ramp,
    input  logic [W-1:0] cust_pat,
    output logic         match
);
    logic [W-1:0] prev_d, prev_q;
    logic [W-1:0] pat_rev;
    logic [W-1:0] prev_inc;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign pat_rev[i] = cust_pat[W-1-i];
    end

    always_comb begin
        prev_d   = cap ? word : prev_q;
        prev_inc = prev_q + W'(1);
        match    = use_ramp ? (word == prev_inc) : (word == pat_rev);
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/adc_align_fsm.sv
// Settle / check / locked / failed search over slip positions.
module adc_align_fsm
    import adc_deser_pkg::*;
#(
    parameter int W        = 12,
    parameter int SETTLE_N = 4,
    parameter int LOCK_N   = 16,
    parameter int SLIP_W   = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              match,
    input  logic              train,
    output logic [SLIP_W-1:0] slip_o,
    output logic              lock_o,
    output logic              err_o,
    output logic              fail_o
);
    localparam int CNT_MAX = (SETTLE_N > LOCK_N) ? SETTLE_N : LOCK_N;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0]  SETTLE_LAST = CNT_W'(SETTLE_N - 1);
    localparam logic [CNT_W-1:0]  LOCK_LAST   = CNT_W'(LOCK_N - 1);
    localparam logic [SLIP_W-1:0] SLIP_LAST   = SLIP_W'(W - 1);

    typedef struct packed {
        align_state_e      st;
        logic [SLIP_W-1:0] slip;
        logic [CNT_W-1:0]  cnt;
        logic              err;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cap) begin
            unique case (s_q.st)
                AL_SETTLE: begin
                    if (s_q.cnt == SETTLE_LAST) begin
                        s_d.st  = AL_CHECK;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
                AL_CHECK: begin
                    if (match) begin
                        if (s_q.cnt == LOCK_LAST) begin
                            s_d.st  = AL_LOCKED;
                            s_d.cnt = '0;
                        end else begin
                            s_d.cnt = s_q.cnt + CNT_W'(1);
                        end
                    end else begin
                        s_d.cnt = '0;
                        if (s_q.slip == SLIP_LAST) begin
                            s_d.st = AL_FAILED;
                        end else begin
                            s_d.slip = s_q.slip + SLIP_W'(1);
                            s_d.st   = AL_SETTLE;
                        end
                    end
                end
                AL_LOCKED: begin
                    if (train && !match) begin
                        s_d.st  = AL_CHECK;
                        s_d.cnt = '0;
                        s_d.err = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        slip_o = s_q.slip;
        lock_o = (s_q.st == AL_LOCKED);
        err_o  = s_q.err;
        fail_o = (s_q.st == AL_FAILED);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '{st: AL_SETTLE, slip: '0, cnt: '0, err: 1'b0};
        else     s_q <= s_d;
    end
endmodule

// File: rtl/adc_lane_deser.sv
// Top: serial lane to signed samples with training alignment.
module adc_lane_deser #(
    parameter int WORD_W        = 12,
    parameter int SETTLE_FRAMES = 4,
    parameter int LOCK_WORDS    = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sdata,
    input  logic                     frame,
    input  logic                     train,
    input  logic                     use_ramp,
    input  logic [WORD_W-1:0]        cust_pat,
    output logic signed [WORD_W-1:0] sample,
    output logic                     valid,
    output logic                     lock,
    output logic                     err,
    output logic                     fail
);
    localparam int SLIP_W = $clog2(WORD_W);
    localparam logic [WORD_W-1:0] SIGN_FLIP = WORD_W'(1) << (WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] smp;
        logic              vld;
    } out_t;

    logic [SLIP_W-1:0] slip_w;
    logic [WORD_W-1:0] word_w;
    logic              match_w;
    out_t              o_d, o_q;

    adc_bit_window #(.W(WORD_W), .SLIP_W(SLIP_W)) u_win (
        .clk    (clk),
        .rst    (rst),
        .sdata  (sdata),
        .slip   (slip_w),
        .word_o (word_w)
    );

    adc_pattern_check #(.W(WORD_W)) u_pat (
        .clk      (clk),
        .rst      (rst),
        .cap      (frame),
        .word     (word_w),
        .use_ramp (use_ramp),
        .cust_pat (cust_pat),
        .match    (match_w)
    );

    adc_align_fsm #(
        .W(WORD_W), .SETTLE_N(SETTLE_FRAMES), .LOCK_N(LOCK_WORDS), .SLIP_W(SLIP_W)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cap    (frame),
        .match  (match_w),
        .train  (train),
        .slip_o (slip_w),
        .lock_o (lock),
        .err_o  (err),
        .fail_o (fail)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = frame;
        if (frame) o_d.smp = word_w ^ SIGN_FLIP;
        sample  = $signed(o_q.smp);
        valid   = o_q.vld;
    end

    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end
endmodule

// File: rtl/adc_lane_deser_chk.sv
module adc_lane_deser_chk #(
    parameter int W      = 12,
    parameter int SLIP_W = $clog2(W)
) (
    input logic                clk,
    input logic                rst,
    input logic                frame,
    input logic                train,
    input logic                valid,
    input logic signed [W-1:0] sample,
    input logic                lock,
    input logic                err,
    input logic                fail,
    input logic [SLIP_W-1:0]   slip,
    input logic                match
);
    a_r3_valid_after_frame: assert property (@(posedge clk) disable iff (rst)
        frame |=> valid);
    a_r3_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
        !frame |=> !valid);
    a_r3_sample_held: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(sample));
    a_r4_slip_at_frame: assert property (@(posedge clk) disable iff (rst)
        !$stable(slip) |-> $past(frame));
    a_r4_slip_one_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(slip) |-> (int'(slip) == int'($past(slip)) + 1));
    a_r4_slip_range: assert property (@(posedge clk) disable iff (rst)
        int'(slip) <= W - 1);
    a_r8_lock_after_match: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(match && frame));
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    a_r10_live_keeps_lock: assert property (@(posedge clk) disable iff (rst)
        (lock && !train) |=> lock);
    a_r11_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        fail |=> fail);
    a_r11_fail_not_lock: assert property (@(posedge clk) disable iff (rst)
        !(lock && fail));
    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> (!lock && !err && !fail && !valid && slip == '0));
endmodule

bind adc_lane_deser adc_lane_deser_chk #(.W(WORD_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .frame  (frame),
    .train  (train),
    .valid  (valid),
    .sample (sample),
    .lock   (lock),
    .err    (err),
    .fail   (fail),
    .slip   (slip_w),
    .match  (match_w)
);

// File: tb/adc_lane_deser_tb.sv
module adc_lane_deser_tb;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic               rst = 1'b1, sdata = 1'b0, frame = 1'b0;
    logic               train = 1'b1, use_ramp = 1'b0;
    logic [11:0]        cust_pat = 12'h000;
    logic signed [11:0] sample;
    logic               valid, lock, err, fail;

    adc_lane_deser u_dut (
        .clk(clk), .rst(rst), .sdata(sdata), .frame(frame), .train(train),
        .use_ramp(use_ramp), .cust_pat(cust_pat), .sample(sample),
        .valid(valid), .lock(lock), .err(err), .fail(fail)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // stream generator state
    int          fpos = 0;
    bit          mode_ramp = 0;
    logic [11:0] cval = 12'h000, rampv = 12'h000;

    task automatic send_word(input logic [11:0] w);
        for (int b = 0; b < 12; b++) begin
            @(negedge clk);
            sdata = w[b];
            frame = (b == fpos);
        end
    endtask

    task automatic stream(input int n);
        for (int i = 0; i < n; i++) begin
            send_word(mode_ramp ? rampv : cval);
            if (mode_ramp) rampv = rampv + 12'd1;
        end
    endtask

    // output monitor
    int                 vcnt = 0, ramp_bad = 0, dbl = 0;
    bit                 have_prev = 0, vprev = 0;
    logic signed [11:0] prev_s = '0, last_s = '0;
    always @(negedge clk) begin
        if (!rst && valid) begin
            vcnt++;
            if (have_prev && (12'(sample - prev_s) != 12'd1)) ramp_bad++;
            prev_s    = sample;
            have_prev = 1;
            last_s    = sample;
            if (vprev) dbl++;
        end
        vprev = valid;
    end

    task automatic win_clear();
        vcnt = 0; ramp_bad = 0; have_prev = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1; sdata = 1'b0; frame = 1'b0;
        repeat (3) @(negedge clk);
        check(lock == 0 && err == 0 && fail == 0 && valid == 0, "R12 reset state",
              {lock, err, fail, valid}, 0);
        rst = 1'b0;
    endtask

    function automatic int to_signed(input logic [11:0] code);
        logic [11:0] f;
        f = code ^ 12'h800;
        return int'($signed(f));
    endfunction

    typedef struct packed {
        logic        ramp;
        logic [11:0] cust;
        logic [11:0] tx;
        logic [3:0]  fp;
        logic        exp_lock;
        logic        exp_fail;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{1'b0, 12'hFFE, 12'h7FF, 4'd0,  1'b1, 1'b0},
        '{1'b0, 12'hFFE, 12'h7FF, 4'd3,  1'b1, 1'b0},
        '{1'b0, 12'h5A3, 12'hC5A, 4'd5,  1'b1, 1'b0},
        '{1'b1, 12'h000, 12'h000, 4'd0,  1'b1, 1'b0},
        '{1'b1, 12'h000, 12'h000, 4'd7,  1'b1, 1'b0},
        '{1'b1, 12'h000, 12'h000, 4'd11, 1'b1, 1'b0},
        '{1'b0, 12'hFFE, 12'h000, 4'd2,  1'b0, 1'b1}
    };

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        // table walk: R1 R4 R6 R7 R8 R11 with R2 R3 on the samples
        foreach (VEC[k]) begin
            do_reset();
            train = 1'b1; use_ramp = VEC[k].ramp; cust_pat = VEC[k].cust;
            mode_ramp = VEC[k].ramp; cval = VEC[k].tx; rampv = 12'hF80;
            fpos = int'(VEC[k].fp);
            stream(120);
            check(lock == VEC[k].exp_lock, "R8 R4 lock after search", lock, VEC[k].exp_lock);
            check(fail == VEC[k].exp_fail, "R11 fail flag", fail, VEC[k].exp_fail);
            if (VEC[k].exp_lock) begin
                win_clear();
                stream(20);
                check(vcnt == 20, "R3 one strobe per word", vcnt, 20);
                if (VEC[k].ramp)
                    check(ramp_bad == 0, "R7 ramp samples step by one across wrap", ramp_bad, 0);
                else
                    check(last_s == to_signed(VEC[k].tx), "R6 R1 reversed pattern sample",
                          last_s, to_signed(VEC[k].tx));
            end
        end

        // R5 exact lock frame, aligned fixed pattern
        do_reset();
        train = 1'b1; use_ramp = 1'b0; cust_pat = 12'hFFE;
        mode_ramp = 0; cval = 12'h7FF; fpos = 0;
        stream(19);
        check(lock == 0, "R5 no lock at frame 19", lock, 0);
        stream(1);
        check(lock == 1, "R5 lock at frame 20", lock, 1);

        // R10 live data ignored by the checker, R2 conversions
        train = 1'b0;
        cval = 12'h000; stream(6);
        check(lock == 1 && err == 0, "R10 live mismatch keeps lock, no error", {lock, err}, 2);
        check(last_s == -2048, "R2 code 0x000", last_s, -2048);
        cval = 12'hFFF; stream(3);
        check(last_s == 2047, "R2 code 0xFFF", last_s, 2047);
        cval = 12'h800; stream(3);
        check(last_s == 0, "R2 code 0x800", last_s, 0);
        cval = 12'h7FF; stream(2);
        train = 1'b1;
        stream(3);
        check(lock == 1 && err == 0, "R10 training resumes clean", {lock, err}, 2);

        // R9 mismatch while locked in training
        cval = 12'h000; stream(1);
        cval = 12'h7FF; stream(1);
        check(lock == 0, "R9 lock dropped", lock, 0);
        check(err == 1, "R9 error set", err, 1);
        stream(25);
        check(lock == 1 && err == 1, "R9 relock keeps sticky error", {lock, err}, 3);

        // R12 reset from locked with error
        do_reset();
        check(dbl == 0, "R3 no back-to-back strobes", dbl, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule